// File: doc/BRIEF.md
# Two-Source Interrupt Level Arbiter

This block sits between a serial peripheral and the CPU. The peripheral has two interrupt sources: a queued SPI engine and an asynchronous UART-style engine. Software programs a 3-bit priority level for each source and one shared 8-bit vector over a byte-wide register bus. Each source raises and drops its own pending flag through set and clear strobes. The block drives the request line that matches the level of the winning pending source. A higher level wins. When the two levels are equal, the SPI source wins.

During an acknowledge, the CPU presents the level it is servicing. If a pending, enabled source has that level, the block flags a response in the same cycle. It returns the shared vector with bit 0 replaced by the identity of the serviced source: 1 for SPI and 0 for UART.

Top module: `irq_level_arb`

## Requirements
- R1: After a synchronous reset, both levels are 0, the vector register reads 0x0F, every request line is low, and reg_rdata is 0.
- R2: The UART level is at address 0 and the SPI level is at address 2. A write stores bits 2:0. A read of either register returns the level in bits 2:0 and zero in bits 7:3, on reg_rdata one cycle after the address is presented.
- R3: The vector register is at address 1. A write stores bits 7:1 and has no effect on bit 0. A read always returns 1 in bit 0.
- R4: A pending source with a non-zero level L drives line irq[L] two clock edges after its set strobe is sampled. All other lines stay low.
- R5: A source with level 0 keeps its pending flag but drives no line. A later write of a non-zero level raises the matching line two edges after the write.
- R6: When both sources are pending with different non-zero levels, only the line of the higher level is driven. At no time is more than one line high.
- R7: When both sources are pending with the same non-zero level, the SPI source wins. An acknowledge at that level returns vector bit 0 = 1.
- R8: A pending flag is cleared only by its own clear strobe. The other source's clear and any acknowledge leave it set.
- R9: While ack is high and ack_lvl equals the non-zero level of a pending source, ack_hit is 1 in the same cycle. ack_vec is then {vector[7:1], s}, where s is 1 for SPI and 0 for UART.
- R10: When ack is low, or no pending enabled source has level ack_lvl, ack_hit is 0 and ack_vec is 0x00.
- R11: When a set strobe and a clear strobe for the same source arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| spi_set | input | 1 | SPI source raises its request |
| spi_clr | input | 1 | SPI source drops its request |
| uart_set | input | 1 | UART source raises its request |
| uart_clr | input | 1 | UART source drops its request |
| ack | input | 1 | Acknowledge strobe from CPU |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_hit | output | 1 | Block responds to this acknowledge |
| ack_vec | output | 8 | Returned vector, bit 0 names the source |
| irq | output | 7 (7:1) | One-hot request lines, index is the level |

## Verification
Several things can fall in the same cycle: both sources pending together, a set meeting a clear, and an acknowledge arriving while both sources hold a request. The stimulus table puts both sources pending at equal, higher and lower levels, and then issues an acknowledge at a chosen level. The winning line on irq and bit 0 of ack_vec are judged against the priority and tie rules. Directed tests drive the set and clear strobes of one source in the same cycle. They also acknowledge while both requests are held and confirm that neither pending flag moves.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    ADR_UART_LVL = 2'd0,
    ADR_VECTOR   = 2'd1,
    ADR_SPI_LVL  = 2'd2,
    ADR_UNUSED   = 2'd3
  } reg_adr_e;

  localparam int SRC_UART = 0;
  localparam int SRC_SPI  = 1;
  localparam int NUM_SRC  = 2;
endpackage

// File: rtl/irq_src_pend.sv
module irq_src_pend (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick #(
  parameter int LVL_W = 3
) (
  input  logic [1:0][LVL_W-1:0] lvl_i,
  input  logic [1:0]            pend_i,
  output logic                  win_act_o,
  output logic                  win_spi_o,
  output logic [LVL_W-1:0]      win_lvl_o
);
  import irq_arb_pkg::*;

  logic s_act, u_act;

  always_comb begin
    s_act = pend_i[SRC_SPI]  && (lvl_i[SRC_SPI]  != '0);
    u_act = pend_i[SRC_UART] && (lvl_i[SRC_UART] != '0);
    win_act_o = s_act || u_act;
    win_spi_o = s_act && (!u_act || (lvl_i[SRC_SPI] >= lvl_i[SRC_UART]));
    if (win_spi_o)  win_lvl_o = lvl_i[SRC_SPI];
    else if (u_act) win_lvl_o = lvl_i[SRC_UART];
    else            win_lvl_o = '0;
  end
endmodule

// File: rtl/irq_ack_match.sv
module irq_ack_match #(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                  ack_i,
  input  logic [LVL_W-1:0]      ack_lvl_i,
  input  logic [1:0][LVL_W-1:0] lvl_i,
  input  logic [1:0]            pend_i,
  input  logic [DATA_W-1:1]     vec_hi_i,
  output logic                  hit_o,
  output logic [DATA_W-1:0]     vec_o
);
  import irq_arb_pkg::*;

  logic s_m, u_m;

  always_comb begin
    s_m = ack_i && pend_i[SRC_SPI] && (lvl_i[SRC_SPI] != '0)
          && (lvl_i[SRC_SPI] == ack_lvl_i);
    u_m = ack_i && pend_i[SRC_UART] && (lvl_i[SRC_UART] != '0)
          && (lvl_i[SRC_UART] == ack_lvl_i);
    hit_o = s_m || u_m;
    vec_o = hit_o ? {vec_hi_i, s_m} : '0;
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int                LVL_W   = 3,
  parameter int                DATA_W  = 8,
  parameter int                ADDR_W  = 2,
  parameter logic [DATA_W-1:0] VEC_RST = 8'h0F
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic                    spi_set,
  input  logic                    spi_clr,
  input  logic                    uart_set,
  input  logic                    uart_clr,
  input  logic                    ack,
  input  logic [LVL_W-1:0]        ack_lvl,
  output logic                    ack_hit,
  output logic [DATA_W-1:0]       ack_vec,
  output logic [(2**LVL_W)-1:1]   irq
);
  import irq_arb_pkg::*;

  localparam int NLINES = (2**LVL_W) - 1;
  localparam int PAD_W  = DATA_W - LVL_W;

  logic [1:0][LVL_W-1:0] lvl_q;
  logic [DATA_W-1:1]     vec_hi_q;
  logic [1:0]            set_v, clr_v, pend_v;
  logic                  win_act, win_spi;
  logic [LVL_W-1:0]      win_lvl;
  logic [NLINES:1]       line_dec;

  assign set_v[SRC_SPI]  = spi_set;
  assign set_v[SRC_UART] = uart_set;
  assign clr_v[SRC_SPI]  = spi_clr;
  assign clr_v[SRC_UART] = uart_clr;

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= '0;
      vec_hi_q <= VEC_RST[DATA_W-1:1];
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_W'(ADR_UART_LVL): lvl_q[SRC_UART] <= reg_wdata[LVL_W-1:0];
        ADDR_W'(ADR_SPI_LVL):  lvl_q[SRC_SPI]  <= reg_wdata[LVL_W-1:0];
        ADDR_W'(ADR_VECTOR):   vec_hi_q        <= reg_wdata[DATA_W-1:1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADDR_W'(ADR_UART_LVL): reg_rdata <= {{PAD_W{1'b0}}, lvl_q[SRC_UART]};
        ADDR_W'(ADR_SPI_LVL):  reg_rdata <= {{PAD_W{1'b0}}, lvl_q[SRC_SPI]};
        ADDR_W'(ADR_VECTOR):   reg_rdata <= {vec_hi_q, 1'b1};
        default:               reg_rdata <= '0;
      endcase
    end
  end

  // one pending flag per source
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    irq_src_pend pend_i (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_v[s]),
      .clr_i  (clr_v[s]),
      .pend_o (pend_v[s])
    );
  end

  irq_lvl_pick #(.LVL_W(LVL_W)) pick_i (
    .lvl_i     (lvl_q),
    .pend_i    (pend_v),
    .win_act_o (win_act),
    .win_spi_o (win_spi),
    .win_lvl_o (win_lvl)
  );

  for (genvar k = 1; k <= NLINES; k++) begin : g_line
    assign line_dec[k] = win_act && (win_lvl == LVL_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= line_dec;
  end

  irq_ack_match #(.LVL_W(LVL_W), .DATA_W(DATA_W)) ack_i (
    .ack_i     (ack),
    .ack_lvl_i (ack_lvl),
    .lvl_i     (lvl_q),
    .pend_i    (pend_v),
    .vec_hi_i  (vec_hi_q),
    .hit_o     (ack_hit),
    .vec_o     (ack_vec)
  );

  logic unused_win_spi;
  assign unused_win_spi = win_spi;
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [DATA_W-1:0]       reg_rdata,
  input logic [(2**LVL_W)-1:1]   irq,
  input logic                    ack,
  input logic                    ack_hit,
  input logic [DATA_W-1:0]       ack_vec,
  input logic [1:0]              pend_v,
  input logic [1:0][LVL_W-1:0]   lvl_q,
  input logic [DATA_W-1:1]       vec_hi_q
);
  // R6
  one_line_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(irq));

  // R4
  spi_drives_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_v[1] && lvl_q[1] != '0) |=> (irq != '0));

  // R4
  uart_drives_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_v[0] && lvl_q[0] != '0) |=> (irq != '0));

  // R10
  no_ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ack |-> (!ack_hit && ack_vec == '0));

  // R9
  vec_upper_chk: assert property (@(posedge clk) disable iff (rst)
    ack_hit |-> (ack_vec[DATA_W-1:1] == vec_hi_q));

  // R3
  vec_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(1)) |=> reg_rdata[0]);

  // R2
  lvl_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(0) || reg_addr == ADDR_W'(2)) |=> (reg_rdata[DATA_W-1:LVL_W] == '0));
endmodule

bind irq_level_arb irq_level_arb_chk #(.LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq(irq),
  .ack(ack), .ack_hit(ack_hit), .ack_vec(ack_vec), .pend_v(pend_v),
  .lvl_q(lvl_q), .vec_hi_q(vec_hi_q)
);

// File: tb/irq_level_arb_tb.sv
module irq_level_arb_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       spi_set = 0, spi_clr = 0, uart_set = 0, uart_clr = 0;
  logic       ack = 0;
  logic [2:0] ack_lvl = '0;
  logic       ack_hit;
  logic [7:0] ack_vec;
  logic [7:1] irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_arb dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_set(spi_set),
    .spi_clr(spi_clr), .uart_set(uart_set), .uart_clr(uart_clr),
    .ack(ack), .ack_lvl(ack_lvl), .ack_hit(ack_hit), .ack_vec(ack_vec),
    .irq(irq)
  );

  typedef struct packed {
    logic [2:0] s_l;
    logic [2:0] u_l;
    logic       s_p;
    logic       u_p;
    logic [2:0] a_l;
    logic [6:0] e_irq;
    logic       e_hit;
    logic [7:0] e_vec;
  } vec_t;

  // vector register holds 0xA4 during the table: SPI returns A5, UART A4
  localparam vec_t TBL [9] = '{
    '{3'd3, 3'd5, 1'b1, 1'b1, 3'd5, 7'b0010000, 1'b1, 8'hA4},
    '{3'd6, 3'd2, 1'b1, 1'b1, 3'd6, 7'b0100000, 1'b1, 8'hA5},
    '{3'd4, 3'd4, 1'b1, 1'b1, 3'd4, 7'b0001000, 1'b1, 8'hA5},
    '{3'd0, 3'd0, 1'b1, 1'b1, 3'd0, 7'b0000000, 1'b0, 8'h00},
    '{3'd7, 3'd1, 1'b1, 1'b0, 3'd1, 7'b1000000, 1'b0, 8'h00},
    '{3'd2, 3'd7, 1'b0, 1'b1, 3'd7, 7'b1000000, 1'b1, 8'hA4},
    '{3'd0, 3'd3, 1'b1, 1'b1, 3'd3, 7'b0000100, 1'b1, 8'hA4},
    '{3'd5, 3'd5, 1'b0, 1'b1, 3'd5, 7'b0010000, 1'b1, 8'hA4},
    '{3'd1, 3'd6, 1'b1, 1'b1, 3'd2, 7'b0100000, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    tick();
    chk(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic pulse(input logic s_set, input logic s_clr, input logic u_set, input logic u_clr);
    spi_set = s_set; spi_clr = s_clr; uart_set = u_set; uart_clr = u_clr;
    tick();
    spi_set = 0; spi_clr = 0; uart_set = 0; uart_clr = 0;
  endtask

  task automatic ack_chk(input logic [2:0] l, input logic e_hit, input logic [7:0] e_vec, input string req);
    ack = 1'b1; ack_lvl = l;
    #1;
    chk(req, {31'd0, ack_hit}, {31'd0, e_hit});
    chk(req, {24'd0, ack_vec}, {24'd0, e_vec});
    tick();
    ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {25'd0, irq}, 32'd0);
    chk("R1 rdata", {24'd0, reg_rdata}, 32'd0);
    rd_chk(2'd0, 8'h00, "R1 uart level");
    rd_chk(2'd2, 8'h00, "R1 spi level");
    rd_chk(2'd1, 8'h0F, "R1 vector");
    // R2 level fields
    wr(2'd2, 8'hFF);
    rd_chk(2'd2, 8'h07, "R2 spi level pad");
    wr(2'd0, 8'hFA);
    rd_chk(2'd0, 8'h02, "R2 uart level pad");
    // R3 vector bit 0
    wr(2'd1, 8'h00);
    rd_chk(2'd1, 8'h01, "R3 bit0 reads one");
    wr(2'd1, 8'hA4);
    rd_chk(2'd1, 8'hA5, "R3 upper bits stored");

    // table walk: R4 R6 R7 R9 R10
    foreach (TBL[i]) begin
      pulse(0, 1, 0, 1);
      wr(2'd2, {5'd0, TBL[i].s_l});
      wr(2'd0, {5'd0, TBL[i].u_l});
      pulse(TBL[i].s_p, 0, TBL[i].u_p, 0);
      tick();
      chk($sformatf("R4/R6 row %0d irq", i), {25'd0, irq}, {25'd0, TBL[i].e_irq});
      ack_chk(TBL[i].a_l, TBL[i].e_hit, TBL[i].e_vec, $sformatf("R9/R10/R7 row %0d ack", i));
    end

    // R5 level 0 holds the request
    pulse(0, 1, 0, 1);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    pulse(1, 0, 0, 0);
    tick();
    chk("R5 level0 no line", {25'd0, irq}, 32'd0);
    wr(2'd2, 8'h03);
    tick();
    chk("R5 held request raises line3", {25'd0, irq}, 32'b0000100);

    // R8 only own clear drops request; ack does not
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h02);
    pulse(0, 0, 1, 0);
    tick();
    chk("R8 setup line5", {25'd0, irq}, 32'b0010000);
    ack_chk(3'd5, 1'b1, 8'hA5, "R8 ack spi");
    tick();
    chk("R8 ack keeps line5", {25'd0, irq}, 32'b0010000);
    pulse(0, 0, 0, 1);
    tick();
    chk("R8 uart clear keeps line5", {25'd0, irq}, 32'b0010000);
    pulse(0, 1, 0, 0);
    tick();
    chk("R8 spi clear drops line5", {25'd0, irq}, 32'd0);
    ack_chk(3'd2, 1'b0, 8'h00, "R8 uart cleared no hit");
    ack_chk(3'd0, 1'b0, 8'h00, "R10 level zero never hits");

    // R11 set beats clear
    pulse(1, 1, 0, 0);
    tick();
    chk("R11 spi set wins", {25'd0, irq}, 32'b0010000);
    pulse(0, 0, 1, 1);
    ack_chk(3'd2, 1'b1, 8'hA4, "R11 uart set wins");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule